// File: doc/BRIEF.md
# Packed SIMD Shifter with Rounding and Saturation

This block shifts every lane of a 32-bit packed word by its own amount. The destination register number picks the lane width. Registers 2 to 15 hold four 8-bit lanes. Registers 16 to 29 hold two 16-bit lanes. Any other register number leaves the source word untouched.

Three shift kinds are available: arithmetic right, logical right and left. The shift amount can come from two places. In the register form, each lane of a second operand word gives the amount for the same lane. In the immediate form, an 8-bit immediate is assembled from a 3-bit upper part and a 5-bit lower part, and the same value is applied to every lane.

A two-bit mode field chooses between the plain shift and a modified shift. The modification depends on direction. A right shift becomes a rounding shift. A left shift becomes a signed saturating shift.

The shift datapath is combinational. Its result is captured in an output register one clock after the request.

Top module: `pack_shift_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `out_word` is 0.
- R2: A request presented with `in_valid` high appears on `out_word` with `out_valid` high after exactly one rising clock edge. In a cycle with `in_valid` low, `out_valid` goes to 0 and `out_word` keeps its previous value.
- R3: The value of `dst_idx` sets the lane layout:
  - 2 to 15 gives four 8-bit lanes.
  - 16 to 29 gives two 16-bit lanes.
  - 0, 1, 30 and 31 return `src_val` unchanged.
- R4: The shift amount source is chosen by `imm_sel`:
  - With `imm_sel`=0, lane k uses lane k of `amt_val`.
  - With `imm_sel`=1, every lane uses the 8-bit value {`imm_hi`,`imm_lo`}.
  - In both cases only the low 3 bits (8-bit lanes) or low 4 bits (16-bit lanes) of the amount are used.
- R5: `op_sel` encodes the operation: 00 is arithmetic right shift, 01 is logical right shift, 10 is left shift, and 11 returns `src_val` unchanged.
- R6: `mm`=01 selects the modified shift. The values 00, 10 and 11 select the plain shift.
- R7: A modified right shift (arithmetic or logical) adds the last bit shifted out to the shifted lane. Lanes stay independent, so no carry passes between them.
- R8: A modified left shift clamps a lane when the shifted value does not fit the lane as a signed number:
  - A lane whose source is negative becomes the signed minimum (0x80 or 0x8000).
  - Any other lane becomes the signed maximum (0x7F or 0x7FFF).
  - A lane that fits gets the plain left shift result.
- R9: A lane whose effective shift amount is zero is returned unchanged, for every operation and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| dst_idx | input | 5 | Destination register number; selects the lane width |
| op_sel | input | 2 | 00 arithmetic right, 01 logical right, 10 left, 11 pass |
| mm | input | 2 | Mode field; 01 selects rounding or saturation |
| imm_sel | input | 1 | 1 selects the immediate amount, 0 the per-lane register amount |
| imm_hi | input | 3 | Upper three bits of the immediate amount |
| imm_lo | input | 5 | Lower five bits of the immediate amount |
| src_val | input | 32 | Packed source word |
| amt_val | input | 32 | Packed per-lane shift amounts |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_word | output | 32 | Registered shifted word |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 8-bit narrow lanes, 16-bit wide lanes, and bank edges at registers 2, 16 and 29.

With these values every register number can be reached, including the four pass-through numbers at both ends of the range. Every shift amount, including the wrap past the lane width, is also reachable.

The directed vectors target the extreme lane values 0x80, 0x7F, 0x8000 and 0xFFFF. Alongside them, random vectors are compared against a lane-by-lane integer model.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

  typedef enum logic [1:0] {
    SOP_SRA  = 2'b00,
    SOP_SRL  = 2'b01,
    SOP_SLL  = 2'b10,
    SOP_PASS = 2'b11
  } shift_op_e;

  localparam logic [1:0] MM_MODIFY = 2'b01;

  function automatic logic mode_is_modified(input logic [1:0] mode);
    return mode == MM_MODIFY;
  endfunction

endpackage

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int IDX_W     = 5,
  parameter int NARROW_LO = 2,
  parameter int WIDE_LO   = 16,
  parameter int WIDE_HI   = 29
) (
  input  logic [IDX_W-1:0] idx,
  output logic             is_narrow,
  output logic             is_wide
);
  localparam int IDX_MAX = (1 << IDX_W) - 1;
  localparam logic [IDX_W-1:0] N_LO = IDX_W'(NARROW_LO);
  localparam logic [IDX_W-1:0] W_LO = IDX_W'(WIDE_LO);
  localparam logic [IDX_W-1:0] W_HI = IDX_W'(WIDE_HI);

  always_comb begin
    is_narrow = (idx >= N_LO) && (idx < W_LO);
    is_wide   = (idx >= W_LO) && (idx <= W_HI);
  end

  initial begin
    assert_bank_order_R3: assert (NARROW_LO < WIDE_LO && WIDE_LO <= WIDE_HI && WIDE_HI <= IDX_MAX)
      else $error("bank edges out of order");
  end
endmodule

// File: rtl/lane_shift.sv
module lane_shift
  import pshift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] amt,
  input  shift_op_e    op,
  input  logic         modify,
  output logic [W-1:0] y
);
  localparam int A = $clog2(W);

  logic [A-1:0]   sh;
  logic [W-1:0]   sra_p, srl_p, sll_p, sat_v;
  logic [2*W-1:0] ext, ext_sh;
  logic           last_out, ovf;

  assign sh = amt[A-1:0];

  always_comb begin
    sra_p    = W'($signed(x) >>> sh);
    srl_p    = x >> sh;
    last_out = (sh == '0) ? 1'b0 : x[sh - A'(1)];
    ext      = {{W{x[W-1]}}, x};
    ext_sh   = ext << sh;
    sll_p    = ext_sh[W-1:0];
    ovf      = ext_sh[2*W-1:W] != {W{ext_sh[W-1]}};
    sat_v    = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    unique case (op)
      SOP_SRA: y = sra_p + {{(W-1){1'b0}}, modify & last_out};
      SOP_SRL: y = srl_p + {{(W-1){1'b0}}, modify & last_out};
      SOP_SLL: y = (modify && ovf) ? sat_v : sll_p;
      default: y = x;
    endcase

    if (sh == '0) begin
      assert_zero_amt_R9: assert (y == x) else $error("zero shift changed lane");
    end
    if (op == SOP_SRL && sh != '0) begin
      assert_srl_bound_R7: assert (!y[W-1] || y == {1'b1, {(W-1){1'b0}}})
        else $error("logical right shift out of range");
    end
    if (op == SOP_SLL && modify) begin
      assert_sign_kept_R8: assert (y[W-1] == x[W-1] || x == '0)
        else $error("saturating left shift flipped sign");
    end
  end
endmodule

// File: rtl/pack_shift_unit.sv
module pack_shift_unit
  import pshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NARROW_W  = 8,
  parameter int WIDE_W    = 16,
  parameter int IDX_W     = 5,
  parameter int IMM_HI_W  = 3,
  parameter int IMM_LO_W  = 5,
  parameter int NARROW_LO = 2,
  parameter int WIDE_LO   = 16,
  parameter int WIDE_HI   = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [IDX_W-1:0]    dst_idx,
  input  logic [1:0]          op_sel,
  input  logic [1:0]          mm,
  input  logic                imm_sel,
  input  logic [IMM_HI_W-1:0] imm_hi,
  input  logic [IMM_LO_W-1:0] imm_lo,
  input  logic [DATA_W-1:0]   src_val,
  input  logic [DATA_W-1:0]   amt_val,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_word
);
  localparam int N_NAR = DATA_W / NARROW_W;
  localparam int N_WID = DATA_W / WIDE_W;
  localparam int IMM_W = IMM_HI_W + IMM_LO_W;

  logic [IMM_W-1:0]  imm_amt;
  logic              is_narrow, is_wide, modify;
  shift_op_e         op;
  logic [DATA_W-1:0] nar_res, wid_res, res;

  assign imm_amt = {imm_hi, imm_lo};
  assign modify  = mode_is_modified(mm);
  assign op      = shift_op_e'(op_sel);

  bank_decode #(
    .IDX_W(IDX_W), .NARROW_LO(NARROW_LO), .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI)
  ) u_bank (
    .idx(dst_idx), .is_narrow(is_narrow), .is_wide(is_wide)
  );

  for (genvar g = 0; g < N_NAR; g++) begin : g_nar
    logic [NARROW_W-1:0] lane_amt;
    assign lane_amt = imm_sel ? NARROW_W'(imm_amt) : amt_val[g*NARROW_W +: NARROW_W];
    lane_shift #(.W(NARROW_W)) u_lane (
      .x(src_val[g*NARROW_W +: NARROW_W]), .amt(lane_amt), .op(op), .modify(modify),
      .y(nar_res[g*NARROW_W +: NARROW_W])
    );
  end

  for (genvar g = 0; g < N_WID; g++) begin : g_wid
    logic [WIDE_W-1:0] lane_amt;
    assign lane_amt = imm_sel ? WIDE_W'(imm_amt) : amt_val[g*WIDE_W +: WIDE_W];
    lane_shift #(.W(WIDE_W)) u_lane (
      .x(src_val[g*WIDE_W +: WIDE_W]), .amt(lane_amt), .op(op), .modify(modify),
      .y(wid_res[g*WIDE_W +: WIDE_W])
    );
  end

  always_comb begin
    if (is_narrow)    res = nar_res;
    else if (is_wide) res = wid_res;
    else              res = src_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= res;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("result strobe missing");
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_word))) else $error("idle cycle disturbed output");
  assert_outside_bank_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (dst_idx < IDX_W'(NARROW_LO) || dst_idx > IDX_W'(WIDE_HI)))
      |=> out_word == $past(src_val)) else $error("unbanked register altered word");
  assert_pass_op_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> out_word == $past(src_val))
    else $error("pass op altered word");
endmodule

// File: tb/sim_pack_shift_unit.sv
module sim_pack_shift_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  dst_idx;
  logic [1:0]  op_sel, mm;
  logic        imm_sel;
  logic [2:0]  imm_hi;
  logic [4:0]  imm_lo;
  logic [31:0] src_val, amt_val;
  logic        out_valid;
  logic [31:0] out_word;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pack_shift_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dst_idx(dst_idx), .op_sel(op_sel),
    .mm(mm), .imm_sel(imm_sel), .imm_hi(imm_hi), .imm_lo(imm_lo),
    .src_val(src_val), .amt_val(amt_val), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [31:0] model(input int d, input logic [31:0] s, input logic [31:0] a,
                                        input bit isel, input int ih, input int il,
                                        input int op, input int mode);
    logic [31:0] r;
    int w, n, mx, mn;
    bit md;
    if (d < 2 || d > 29 || op == 3) return s;
    w  = (d < 16) ? 8 : 16;
    n  = 32 / w;
    md = (mode == 1);
    mx = (1 << (w - 1)) - 1;
    mn = -(1 << (w - 1));
    r  = '0;
    for (int k = 0; k < n; k++) begin
      int x, sx, amt, sh, v;
      x   = int'((s >> (k * w)) & ((32'd1 << w) - 1));
      sx  = (x > mx) ? x - (1 << w) : x;
      amt = isel ? (ih * 32 + il) : int'((a >> (k * w)) & ((32'd1 << w) - 1));
      sh  = amt % w;
      case (op)
        0: begin v = sx >>> sh; if (md && sh > 0) v = v + ((sx >>> (sh - 1)) & 1); end
        1: begin v = x >> sh;   if (md && sh > 0) v = v + ((x >> (sh - 1)) & 1); end
        default: begin
          v = sx * (1 << sh);
          if (md && (v > mx || v < mn)) v = (sx < 0) ? mn : mx;
        end
      endcase
      r = r | ((32'(v) & ((32'd1 << w) - 1)) << (k * w));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, checks at the next falling edge.
  task automatic apply(input string tag, input int d, input int op, input int mode, input bit isel,
                       input int ih, input int il, input logic [31:0] s, input logic [31:0] a);
    logic [31:0] exp;
    dst_idx = 5'(d); op_sel = 2'(op); mm = 2'(mode); imm_sel = isel;
    imm_hi = 3'(ih); imm_lo = 5'(il); src_val = s; amt_val = a; in_valid = 1'b1;
    exp = model(d, s, a, isel, ih, il, op, mode);
    @(negedge clk);
    check(tag, out_word, exp);
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst = 1'b1; in_valid = 1'b0; dst_idx = '0; op_sel = '0; mm = '0; imm_sel = 1'b0;
    imm_hi = '0; imm_lo = '0; src_val = '0; amt_val = '0;
    repeat (3) @(negedge clk);
    check("R1 reset word", out_word, 32'd0);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {out_valid, out_word[30:0]}, 32'd0);

    apply("R5 sra narrow",        3, 0, 0, 0, 0, 0, 32'h80F07F01, 32'h01010101);
    apply("R7 sra round narrow",  3, 0, 1, 0, 0, 0, 32'h80F07F03, 32'h01020101);
    apply("R5 srl wide",         20, 1, 0, 0, 0, 0, 32'hFFFF8001, 32'h00040001);
    apply("R7 srl round no carry", 25, 1, 1, 0, 0, 0, 32'hFFFFFFFF, 32'h00010001);
    apply("R5 sll narrow",       10, 2, 0, 0, 0, 0, 32'h40C00181, 32'h01010101);
    apply("R8 sll sat narrow",   10, 2, 1, 0, 0, 0, 32'h40C00181, 32'h01010101);
    apply("R8 sll sat wide",     17, 2, 1, 0, 0, 0, 32'h4000C001, 32'h00020002);
    apply("R8 sll sat fits",     17, 2, 1, 0, 0, 0, 32'hFFFF0003, 32'h000F0003);
    apply("R4 imm narrow",        5, 1, 0, 1, 5, 2, 32'hF0804020, 32'h07070707);
    apply("R4 imm wide mod16",   28, 0, 0, 1, 7, 19, 32'h8000F00F, 32'h0);
    apply("R4 reg amt modulo",    2, 1, 0, 0, 0, 0, 32'h80808080, 32'h09112131);
    apply("R6 mm10 plain",       12, 0, 2, 0, 0, 0, 32'h03030303, 32'h01010101);
    apply("R6 mm11 plain",       22, 2, 3, 0, 0, 0, 32'h40004000, 32'h00010001);
    apply("R5 pass op",           9, 3, 1, 0, 0, 0, 32'h12345678, 32'h03030303);
    apply("R3 reg0 pass",         0, 0, 0, 0, 0, 0, 32'h87654321, 32'h01010101);
    apply("R3 reg1 pass",         1, 2, 1, 0, 0, 0, 32'h87654321, 32'h01010101);
    apply("R3 reg30 pass",       30, 1, 0, 0, 0, 0, 32'h87654321, 32'h01010101);
    apply("R3 reg31 pass",       31, 2, 0, 0, 0, 0, 32'h87654321, 32'h01010101);
    apply("R3 edge reg15 narrow", 15, 1, 0, 0, 0, 0, 32'hFF00FF00, 32'h04040404);
    apply("R3 edge reg16 wide",   16, 1, 0, 0, 0, 0, 32'hFF00FF00, 32'h00040004);
    apply("R3 edge reg29 wide",   29, 0, 1, 0, 0, 0, 32'h8001FFFF, 32'h00010004);
    apply("R9 zero amt sra round", 4, 0, 1, 0, 0, 0, 32'h81FF7F00, 32'h08000810);
    apply("R9 zero amt sll sat",  18, 2, 1, 1, 0, 16, 32'h7FFF8000, 32'h0);

    // R2: idle cycle keeps the word and drops the strobe
    held = out_word;
    in_valid = 1'b0; src_val = 32'hDEADBEEF; dst_idx = 5'd0;
    @(negedge clk);
    check("R2 hold word", out_word, held);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < 600; i++) begin
      apply("R3-mix random", int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 31)), $urandom, $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule